// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Counter

This block is a chain of identical 4-bit synchronous up-counter stages that share one clock. Each stage can be cleared to zero, loaded in parallel from a data bus, advanced by one, or held. All of these take effect on the rising clock edge, and every bit of every stage changes at the same edge. Each stage has two count enables. The "park" enable (P) gates counting only. The "trickle" enable (T) gates counting and also qualifies the stage's carry output. A stage raises its carry when it sits at all ones while its trickle enable is high.

The top module wraps a parameterised number of stages into one wide counter. Three 4-bit stages give a 12-bit counter by default. In the chain, the carry of each stage drives the trickle enable of the stage above it. The park enable is shared by all stages. The top carry output therefore marks the point at which the whole counter is about to wrap, and it can feed a further chain. An asynchronous active-low reset puts every stage at zero.

Top module: `casc_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 regardless of the clock. After release, it stays 0 until a synchronous operation changes it.
- R2: When `clr_n` is low at a rising edge, `count` becomes 0 on that edge. This overrides `load_n`, `en_p` and `en_t`.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `count` takes the value of `din` on that edge, whatever the enables are.
- R4: When `clr_n` and `load_n` are both high, `count` advances by one on a rising edge only if `en_p` and `en_t` are both high. In every other case it holds its value.
- R5: `carry_out` is combinational and equals `en_t` AND (`count` equals all ones). `en_p` has no effect on it.
- R6: A stage advances from the carry of the stage below it. The whole bus therefore counts in plain binary: a low stage that sits at 1111 passes its carry upward on the same edge, for example 0x0FF becomes 0x100. When `en_p` is low, no stage moves, even if lower stages sit at all ones.
- R7: When counting is enabled, a count of all ones wraps to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| rst_n | input | 1 | Asynchronous active-low reset to zero |
| clr_n | input | 1 | Synchronous active-low clear, highest priority |
| load_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Park enable, gates counting in all stages |
| en_t | input | 1 | Trickle enable of the lowest stage, also qualifies the carry |
| din | input | 12 | Parallel load data |
| count | output | 12 | Current count |
| carry_out | output | 1 | High when en_t is set and the count is all ones |

## Verification
The counter is driven through long runs of plain counting, with en_p and en_t each dropped on its own. This separates the count gate, which needs both enables, from the carry gate, which needs only en_t. Loads of 0x00F, 0x0FF and 0xFFF followed by a count show whether the carry passes correctly into the second and third stages and whether the whole bus wraps. Clear and load are applied with every enable set, and together with each other, to pin down the priority order. A reset asserted in mid-cycle shows that the reset acts asynchronously.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
// Resolves the synchronous controls into one operation, clear first.
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  always_comb begin
    if (!clr_n)            op = OP_CLEAR;
    else if (!load_n)      op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
// One counter slice: next-state logic, state register, qualified carry.
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [STAGE_W-1:0] d,
  output logic [STAGE_W-1:0] q,
  output logic               rco
);
  cnt_op_e            op;
  logic [STAGE_W-1:0] q_r;
  logic [STAGE_W-1:0] q_nxt;
  logic               q_we;

  cnt_ctrl u_ctrl (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  always_comb begin
    q_nxt = q_r;
    q_we  = 1'b1;
    case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = q_r + STAGE_W'(1);
      default:  q_we  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_we) q_r <= q_nxt;
  end

  assign q   = q_r;
  assign rco = en_t & (&q_r);

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));
  p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> (q == $past(d)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && en_p && en_t) |=> (q == STAGE_W'($past(q) + 1)));
endmodule

// File: rtl/casc_counter.sv
// Chain of counter slices; each slice's carry drives the trickle enable above.
module casc_counter #(
  parameter int STAGE_W  = 4,
  parameter int N_STAGES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          en_p,
  input  logic                          en_t,
  input  logic [STAGE_W*N_STAGES-1:0]   din,
  output logic [STAGE_W*N_STAGES-1:0]   count,
  output logic                          carry_out
);
  localparam int TOTAL_W = STAGE_W * N_STAGES;

  logic [N_STAGES:0] t_chain;
  assign t_chain[0] = en_t;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    cnt_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_n (clr_n),
      .load_n(load_n),
      .en_p  (en_p),
      .en_t  (t_chain[s]),
      .d     (din[s*STAGE_W +: STAGE_W]),
      .q     (count[s*STAGE_W +: STAGE_W]),
      .rco   (t_chain[s+1])
    );
  end

  assign carry_out = t_chain[N_STAGES];

  p_carry_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_t && (count == {TOTAL_W{1'b1}})));
  p_cascade_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && en_p && en_t) |=> (count == TOTAL_W'($past(count) + 1)));
  p_park_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !en_p) |=> $stable(count));
endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;
  localparam int W = 12;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n, clr_n, load_n, en_p, en_t;
  logic [W-1:0] din;
  logic [W-1:0] count;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  casc_counter dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .din(din), .count(count), .carry_out(carry_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check carry combinationally, clock once, check count.
  task automatic step(input bit c, input bit l, input bit p, input bit t,
                      input int d, input string tag);
    int expc;
    clr_n = c; load_n = l; en_p = p; en_t = t; din = W'(d);
    #1;
    expc = (t && model == MAXV) ? 1 : 0;
    chk(carry_out == expc[0], "R5 carry", int'(carry_out), expc);
    if (!c)         model = 0;
    else if (!l)    model = d & MAXV;
    else if (p && t) model = (model + 1) & MAXV;
    @(negedge clk);
    chk(int'(count) == model, tag, int'(count), model);
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    chk(count == '0, "R1 reset", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == '0, "R1 after release", int'(count), 0);

    for (int i = 0; i < 20; i++) step(1, 1, 1, 1, 0, "R4 count");
    step(1, 1, 0, 1, 0, "R4 hold p low");
    step(1, 1, 1, 0, 0, "R4 hold t low");
    step(1, 1, 0, 0, 0, "R4 hold both low");
    step(1, 0, 1, 1, 'h0F, "R3 load over enable");
    step(1, 1, 1, 1, 0, "R6 nibble carry 0x00F");
    step(1, 0, 0, 0, 'h0FF, "R3 load disabled");
    step(1, 1, 1, 1, 0, "R6 carry into top stage 0x0FF");
    step(1, 0, 1, 1, 'hFFF, "R3 load full");
    step(1, 1, 0, 1, 0, "R6 park freezes full");
    step(1, 1, 1, 0, 0, "R5 trickle low full");
    step(1, 1, 1, 1, 0, "R7 wrap to zero");
    step(1, 0, 1, 1, 'hA5C, "R3 load pattern");
    step(0, 0, 1, 1, 'h123, "R2 clear over load");
    step(1, 0, 1, 1, 'h7FE, "R3 load 0x7FE");
    step(1, 1, 1, 1, 0, "R4 count 0x7FF");
    step(1, 1, 1, 1, 0, "R6 count 0x800");
    step(0, 1, 1, 1, 0, "R2 clear over count");
    step(1, 0, 0, 0, 'hEFF, "R3 load 0xEFF");
    step(1, 1, 0, 1, 0, "R6 park with low stages full");

    // asynchronous reset in mid-cycle
    #2 rst_n = 1'b0;
    #1 chk(count == '0, "R1 async reset", int'(count), 0);
    model = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) step(1, 1, 1, 1, 0, "R4 count after reset");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule